// File: doc/BRIEF.md
# Serial GPIO Shift Master

This block widens a chip's general-purpose I/O by scanning a chain of external shift registers. It repeatedly runs frames: a strobe tells the external parallel-load input registers to capture their pins and the external output registers to latch what was shifted into them. A train of shift-clock pulses then moves one output bit out and one input bit in for every configured slot. Every slot therefore carries one input bit and one output bit.

Software reaches the block through a simple APB-style register port. One control register holds the enable, the slot count (in units of eight) and the shift-clock divider. Slots are grouped in banks of 32. Slot `i` lives in bank `i >> 5` at bit `i % 32`. Each bank has three registers. The value register takes output writes and returns the sampled inputs on reads. A readback register returns the output values. A tolerance register marks outputs that keep their value through a synchronous soft reset. Input samples become visible only once a whole frame has ended.

Top module: `serial_gpio_master`

## Requirements
- R1: After `presetn` is released, every register reads 0 and `sg_clk`, `sg_ld` and `sg_dout` are low.
- R2: The control register is at offset 0x54. Bit 0 is enable, bits 10:6 are the slot-count field (slots = field × 8), bits 31:16 are the divider, and all other bits read 0. A field write above MAX_SLOTS/8 stores MAX_SLOTS/8 (10 for the default of 80).
- R3: The shift clock is low for divider+1 bus cycles and then high for divider+1 bus cycles, so its period is 2×(divider+1).
- R4: Each frame starts with `sg_ld` high for 2×(divider+1) cycles with `sg_clk` low. Exactly slot-count clock pulses follow. `sg_ld` and `sg_clk` are never high together.
- R5: Outputs are shifted out highest slot first. The bit that is valid while the k-th clock pulse is high (k from 0) is output slot N−1−k.
- R6: The input bit on `sg_din` at the k-th rising clock edge is stored as input slot N−1−k. Input slots at or above N read 0.
- R7: Value registers change only when a frame ends. A read in the middle of a frame returns the previous complete frame.
- R8: Per-bank offsets are: value 0x00/0x1C/0x38/0x90, readback 0x70/0x74/0x78/0x7C, tolerance 0x18/0x34/0x50/0xA8 (banks 0 to 3). Banks at or beyond ceil(MAX_SLOTS/32), and bits for slots at or above MAX_SLOTS, read 0 and ignore writes.
- R9: Readback returns the output values written through the value register. Those writes never change what the value register reads.
- R10: After enable is cleared, the current frame finishes and the pins then stay low. With enable set and a slot count of 0, no frame starts.
- R11: A soft reset clears the control register, the inputs and every output whose tolerance bit is 0. Tolerated outputs and the tolerance registers keep their values.
- R12: While the block is enabled, frames run back to back. Each frame sends the output values held at its strobe, so a write lands whole in one frame and never splits across two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Asynchronous active-low hard reset |
| soft_rst | input | 1 | Synchronous soft reset that honours output tolerance |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | Write when high, read when low |
| paddr | input | 8 | Register byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| sg_clk | output | 1 | Shift clock to the external chain |
| sg_ld | output | 1 | Load/latch strobe to the external chain |
| sg_dout | output | 1 | Serial output data |
| sg_din | input | 1 | Serial input data |

## Verification
Two events can fall on the same bus cycle: a software write to an output value register, and the frame-start snapshot of the outputs taken on the edge where the strobe rises. The bench provokes this by writing to random banks at random delays while frames run back to back under random dividers and slot counts. An external-chain model rebuilds each received frame from the serial pins. A write that shares its edge with the snapshot must be absent from that frame and present whole in the next one. A frame that holds part of a write, or a stale value, is reported.

// File: rtl/serial_gpio_master.sv
module serial_gpio_master #(
  parameter int MAX_SLOTS = 80,
  parameter int DIV_W = 16,
  parameter int AW = 8
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          soft_rst,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  output logic          sg_clk,
  output logic          sg_ld,
  output logic          sg_dout,
  input  logic          sg_din
);
  localparam int NBANK = (MAX_SLOTS + 31) / 32;
  localparam int W     = NBANK * 32;
  localparam int FMAX  = MAX_SLOTS / 8;
  localparam int CNT_W = $clog2(MAX_SLOTS + 1);
  localparam int IDX_W = $clog2(W);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(8'h54);

  function automatic logic [W-1:0] valid_mask();
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (i < MAX_SLOTS);
    return m;
  endfunction
  localparam logic [W-1:0] VMASK = valid_mask();

  function automatic logic [AW-1:0] val_off(int b);
    case (b)
      0: return AW'(8'h00);
      1: return AW'(8'h1C);
      2: return AW'(8'h38);
      default: return AW'(8'h90);
    endcase
  endfunction

  function automatic logic [AW-1:0] rb_off(int b);
    return AW'(8'h70 + 4 * b);
  endfunction

  function automatic logic [AW-1:0] tol_off(int b);
    case (b)
      0: return AW'(8'h18);
      1: return AW'(8'h34);
      2: return AW'(8'h50);
      default: return AW'(8'hA8);
    endcase
  endfunction

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT} state_t;

  logic             en_q;
  logic [4:0]       fld_q;
  logic [DIV_W-1:0] div_q;
  logic [W-1:0]     out_q, tol_q, in_q, snap_q, cap_q;
  state_t           state_q;
  logic             half_q;
  logic [DIV_W-1:0] dcnt_q, fdiv_q;
  logic [CNT_W-1:0] fcnt_q;
  logic [IDX_W-1:0] bit_q;

  logic             wr, go, tick, frame_end;
  logic [4:0]       wfld;
  logic [CNT_W-1:0] slots;

  assign wr        = psel && penable && pwrite;
  assign wfld      = pwdata[10:6];
  assign slots     = CNT_W'({3'b000, fld_q} << 3);
  assign go        = en_q && (fld_q != '0);
  assign tick      = (dcnt_q == fdiv_q);
  assign frame_end = (state_q == S_SHIFT) && tick && half_q && (bit_q == '0);

  assign sg_clk  = (state_q == S_SHIFT) && half_q;
  assign sg_ld   = (state_q == S_LOAD);
  assign sg_dout = (state_q == S_SHIFT) ? snap_q[bit_q] : 1'b0;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      en_q  <= 1'b0;
      fld_q <= '0;
      div_q <= '0;
      out_q <= '0;
      tol_q <= '0;
    end else if (soft_rst) begin
      en_q  <= 1'b0;
      fld_q <= '0;
      div_q <= '0;
      out_q <= out_q & tol_q;
    end else if (wr) begin
      if (paddr == CTRL_ADDR) begin
        en_q  <= pwdata[0];
        fld_q <= (wfld > 5'(FMAX)) ? 5'(FMAX) : wfld;
        div_q <= pwdata[16 +: DIV_W];
      end
      for (int b = 0; b < NBANK; b++) begin
        if (paddr == val_off(b)) out_q[b*32 +: 32] <= pwdata & VMASK[b*32 +: 32];
        if (paddr == tol_off(b)) tol_q[b*32 +: 32] <= pwdata & VMASK[b*32 +: 32];
      end
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      state_q <= S_IDLE;
      half_q  <= 1'b0;
      dcnt_q  <= '0;
      fdiv_q  <= '0;
      fcnt_q  <= '0;
      bit_q   <= '0;
      snap_q  <= '0;
      cap_q   <= '0;
      in_q    <= '0;
    end else if (soft_rst) begin
      state_q <= S_IDLE;
      half_q  <= 1'b0;
      dcnt_q  <= '0;
      bit_q   <= '0;
      in_q    <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (go) begin
          state_q <= S_LOAD;
          half_q  <= 1'b0;
          dcnt_q  <= '0;
          fdiv_q  <= div_q;
          fcnt_q  <= slots;
          snap_q  <= out_q;
          cap_q   <= '0;
        end
        S_LOAD: begin
          if (!tick) dcnt_q <= dcnt_q + 1'b1;
          else begin
            dcnt_q <= '0;
            half_q <= ~half_q;
            if (half_q) begin
              state_q <= S_SHIFT;
              bit_q   <= IDX_W'(fcnt_q - CNT_W'(1));
            end
          end
        end
        default: begin
          if (!tick) dcnt_q <= dcnt_q + 1'b1;
          else begin
            dcnt_q <= '0;
            if (!half_q) begin
              half_q       <= 1'b1;
              cap_q[bit_q] <= sg_din;
            end else begin
              half_q <= 1'b0;
              if (bit_q == '0) begin
                in_q <= cap_q;
                if (go) begin
                  state_q <= S_LOAD;
                  fdiv_q  <= div_q;
                  fcnt_q  <= slots;
                  snap_q  <= out_q;
                  cap_q   <= '0;
                end else begin
                  state_q <= S_IDLE;
                end
              end else begin
                bit_q <= bit_q - 1'b1;
              end
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    prdata = '0;
    if (paddr == CTRL_ADDR)
      prdata = (32'(div_q) << 16) | {21'b0, fld_q, 5'b0, en_q};
    for (int b = 0; b < NBANK; b++) begin
      if (paddr == val_off(b)) prdata = in_q[b*32 +: 32];
      if (paddr == rb_off(b))  prdata = out_q[b*32 +: 32];
      if (paddr == tol_off(b)) prdata = tol_q[b*32 +: 32];
    end
  end

  p_strobe_clk_excl_r4: assert property (@(posedge pclk) disable iff (!presetn)
    !(sg_ld && sg_clk));

  p_field_sat_r2: assert property (@(posedge pclk) disable iff (!presetn)
    fld_q <= 5'(FMAX));

  p_commit_frame_end_r7: assert property (@(posedge pclk) disable iff (!presetn)
    (!frame_end && !soft_rst) |=> $stable(in_q));

  p_tolerance_keep_r11: assert property (@(posedge pclk) disable iff (!presetn)
    soft_rst |=> (out_q == $past(out_q & tol_q)));

  p_snapshot_hold_r12: assert property (@(posedge pclk) disable iff (!presetn)
    (state_q == S_SHIFT && !soft_rst) |=> (state_q != S_SHIFT || $stable(snap_q)));
endmodule

// File: tb/serial_gpio_master_tb_top.sv
module serial_gpio_master_tb_top;
  localparam int MAX = 80;
  localparam int NB  = 3;

  logic pclk = 1'b0, presetn = 1'b0, soft_rst = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic sg_clk, sg_ld, sg_dout;
  logic sg_din = 1'b0;

  always #4 pclk = ~pclk;

  serial_gpio_master #(.MAX_SLOTS(MAX)) dut_i (
    .pclk(pclk), .presetn(presetn), .soft_rst(soft_rst),
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .sg_clk(sg_clk), .sg_ld(sg_ld), .sg_dout(sg_dout), .sg_din(sg_din));

  int checks = 0, errors = 0, cyc = 0;
  logic [127:0] m_out = '0, m_tol = '0, seen_out = '0;
  logic [127:0] in_pat = '0, frame_in = '0, frame_exp = '0, rx = '0;
  int cur_n = 8, k = 0, ld_rises = 0, frames_done = 0;
  bit in_frame = 1'b0, mon_chk = 1'b0, p_ld = 1'b0, p_clk = 1'b0;

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] nmask(int n);
    logic [127:0] m = '0;
    for (int i = 0; i < n; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [7:0] voff(int b);
    case (b) 0: return 8'h00; 1: return 8'h1C; 2: return 8'h38; default: return 8'h90; endcase
  endfunction
  function automatic logic [7:0] toff(int b);
    case (b) 0: return 8'h18; 1: return 8'h34; 2: return 8'h50; default: return 8'hA8; endcase
  endfunction
  function automatic logic [7:0] roff(int b);
    return 8'(8'h70 + 4 * b);
  endfunction
  function automatic logic [31:0] ctrl_word(int d, int f, bit en);
    return (32'(d) << 16) | (32'(f) << 6) | 32'(en);
  endfunction

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
    for (int b = 0; b < NB; b++) begin
      if (a == voff(b)) m_out[b*32 +: 32] = d & nmask(MAX)[b*32 +: 32];
      if (a == toff(b)) m_tol[b*32 +: 32] = d & nmask(MAX)[b*32 +: 32];
    end
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge pclk); penable = 1;
    @(negedge pclk); d = prdata; psel = 0; penable = 0;
  endtask

  task automatic wait_ld();
    int c = ld_rises;
    wait (ld_rises != c);
  endtask

  // external chain model: collects the serial outputs and drives the serial inputs
  always @(negedge pclk) begin
    #1;
    if (sg_ld && !p_ld) begin
      if (mon_chk) chk(!in_frame, "R4 previous frame had all pulses", 128'(k), 128'(cur_n));
      frame_exp = seen_out & nmask(cur_n);
      frame_in  = in_pat;
      k = 0; rx = '0; in_frame = 1'b1; ld_rises++;
      sg_din = frame_in[cur_n-1];
    end
    if (sg_clk && !p_clk) begin
      if (mon_chk && !in_frame) chk(1'b0, "R4 extra clock pulse", 128'(k + 1), 128'(cur_n));
      rx = {rx[126:0], sg_dout};
      k++;
      if (k == cur_n) begin
        in_frame = 1'b0;
        frames_done++;
        if (mon_chk) chk(rx == frame_exp, "R5 R12 serial output frame", rx, frame_exp);
      end
    end
    if (!sg_clk && p_clk && in_frame) sg_din = frame_in[cur_n-1-k];
    seen_out = m_out;
    p_ld = sg_ld;
    p_clk = sg_clk;
  end

  always @(posedge pclk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL R10 run did not end: actual=%0d cycles expected<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int n, fd0, seed;
    seed = $urandom(32'd4711);
    repeat (5) @(negedge pclk);
    presetn = 1'b1;
    @(negedge pclk);

    // R1 reset state
    chk(!sg_clk && !sg_ld && !sg_dout, "R1 pins low", {sg_clk, sg_ld, sg_dout}, 0);
    apb_rd(8'h54, rd); chk(rd == 0, "R1 ctrl", rd, 0);
    apb_rd(8'h00, rd); chk(rd == 0, "R1 value", rd, 0);
    apb_rd(8'h70, rd); chk(rd == 0, "R1 readback", rd, 0);
    apb_rd(8'h18, rd); chk(rd == 0, "R1 tolerance", rd, 0);

    // R2 control fields and saturation
    apb_wr(8'h54, 32'hFFFF_FFFE);
    apb_rd(8'h54, rd); chk(rd == 32'hFFFF_0280, "R2 saturated field", rd, 32'hFFFF_0280);
    apb_wr(8'h54, ctrl_word(3, 4, 0));
    apb_rd(8'h54, rd); chk(rd == ctrl_word(3, 4, 0), "R2 fields", rd, ctrl_word(3, 4, 0));
    apb_wr(8'h54, 0);

    // R8 bank map, R9 readback separation
    apb_wr(8'h38, 32'hFFFF_FFFF);
    apb_rd(8'h78, rd); chk(rd == 32'h0000_FFFF, "R8 slots above max masked", rd, 32'h0000_FFFF);
    apb_wr(8'h90, 32'hFFFF_FFFF);
    apb_rd(8'h90, rd); chk(rd == 0, "R8 absent bank value", rd, 0);
    apb_rd(8'h7C, rd); chk(rd == 0, "R8 absent bank readback", rd, 0);
    apb_wr(8'h1C, 32'h1234_5678);
    apb_rd(8'h74, rd); chk(rd == 32'h1234_5678, "R9 readback bank1", rd, 32'h1234_5678);
    apb_rd(8'h1C, rd); chk(rd == 0, "R9 value reads inputs", rd, 0);
    apb_wr(8'h50, 32'hFFFF_FFFF);
    apb_rd(8'h50, rd); chk(rd == 32'h0000_FFFF, "R8 tolerance masked", rd, 32'h0000_FFFF);
    apb_wr(8'h50, 0);

    // R3 R4 timing with divider 2, 8 slots
    mon_chk = 1'b1;
    cur_n = 8; in_pat = 128'hA5;
    apb_wr(8'h00, 32'h0000_00C3);
    apb_wr(8'h54, ctrl_word(2, 1, 1));
    do @(negedge pclk); while (!sg_ld);
    n = 0; while (sg_ld) begin n++; @(negedge pclk); end
    chk(n == 6, "R4 strobe length", n, 6);
    n = 0; while (!sg_clk) begin n++; @(negedge pclk); end
    chk(n == 3, "R3 clock low half", n, 3);
    n = 0; while (sg_clk) begin n++; @(negedge pclk); end
    chk(n == 3, "R3 clock high half", n, 3);
    n = 0; while (!sg_clk) begin n++; @(negedge pclk); end
    chk(n == 3, "R3 clock low again", n, 3);
    apb_wr(8'h54, 0);
    repeat (200) @(negedge pclk);
    apb_rd(8'h00, rd); chk(rd == 32'hA5, "R6 input frame", rd, 32'hA5);

    // R7 commit only at frame end
    cur_n = 16; in_pat = 128'h3C5A;
    apb_wr(8'h54, ctrl_word(1, 2, 1));
    wait_ld(); wait_ld();
    in_pat = 128'hE00F;
    wait_ld();
    repeat (20) @(negedge pclk);
    apb_rd(8'h00, rd); chk(rd == 32'h3C5A, "R7 mid-frame value", rd, 32'h3C5A);
    wait_ld();
    apb_rd(8'h00, rd); chk(rd == 32'hE00F, "R7 committed value", rd, 32'hE00F);

    // R10 disable finishes current frame
    apb_wr(8'h54, ctrl_word(0, 2, 1));
    wait_ld();
    fd0 = frames_done;
    apb_wr(8'h54, ctrl_word(0, 2, 0));
    repeat (100) @(negedge pclk);
    chk(frames_done == fd0 + 1, "R10 frame completes", frames_done, fd0 + 1);
    n = 0;
    repeat (200) begin @(negedge pclk); if (sg_clk || sg_ld) n++; end
    chk(n == 0, "R10 idle after disable", n, 0);
    apb_wr(8'h54, ctrl_word(0, 0, 1));
    n = 0;
    repeat (100) begin @(negedge pclk); if (sg_clk || sg_ld) n++; end
    chk(n == 0, "R10 zero slot count", n, 0);
    apb_wr(8'h54, 0);

    // random frames with writes racing the snapshot (R5 R6 R9 R12)
    for (int it = 0; it < 8; it++) begin
      int d, f;
      d = $urandom % 4;
      f = 1 + $urandom % 10;
      cur_n = f * 8;
      in_pat = {$urandom, $urandom, $urandom, $urandom};
      apb_wr(8'h54, ctrl_word(d, f, 1));
      for (int j = 0; j < 4; j++) begin
        int b;
        repeat ($urandom % 200) @(negedge pclk);
        b = $urandom % NB;
        apb_wr(voff(b), $urandom);
      end
      wait_ld(); wait_ld();
      apb_wr(8'h54, 0);
      repeat ((2 * cur_n + 4) * (d + 1) + 20) @(negedge pclk);
      for (int b = 0; b < NB; b++) begin
        logic [127:0] e;
        e = in_pat & nmask(cur_n);
        apb_rd(voff(b), rd); chk(rd == e[b*32 +: 32], "R6 random inputs", rd, e[b*32 +: 32]);
        apb_rd(roff(b), rd); chk(rd == m_out[b*32 +: 32], "R9 random readback", rd, m_out[b*32 +: 32]);
      end
    end

    // R11 soft reset with tolerance
    apb_wr(8'h00, 32'hFFFF_FFFF);
    apb_wr(8'h1C, 32'hA5A5_A5A5);
    apb_wr(8'h18, 32'h0000_FFFF);
    apb_wr(8'h34, 32'h0);
    apb_wr(8'h54, ctrl_word(5, 2, 0));
    @(negedge pclk); soft_rst = 1'b1;
    @(negedge pclk); soft_rst = 1'b0;
    m_out = m_out & m_tol;
    apb_rd(8'h70, rd); chk(rd == 32'h0000_FFFF, "R11 tolerated outputs kept", rd, 32'h0000_FFFF);
    apb_rd(8'h74, rd); chk(rd == 0, "R11 untolerated outputs cleared", rd, 0);
    apb_rd(8'h18, rd); chk(rd == 32'h0000_FFFF, "R11 tolerance kept", rd, 32'h0000_FFFF);
    apb_rd(8'h54, rd); chk(rd == 0, "R11 ctrl cleared", rd, 0);
    apb_rd(8'h00, rd); chk(rd == 0, "R11 inputs cleared", rd, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule